// File: doc/BRIEF.md
# Nested Bracket Match Scanner

This block walks the head of a sequential code tape from a loop bracket to its partner. The caller pulses a start input while the head sits on the starting bracket and gives the scan direction. Forward is used for an opening bracket, and backward for a closing one. The block then steps the head one cell at a time and reads the byte under it. It keeps a nesting depth count and stops with the head resting on the matching bracket.

The block does not fetch bytes and does not decide whether a loop is taken. The caller supplies the byte at the head, along with a flag that says the head is at the last cell in the current scan direction. The caller also moves the head whenever a step strobe is raised.

One depth counter serves both directions. The bracket that deepens the nesting and the one that unwinds it trade places according to the direction. Running off the tape or nesting too deeply ends the scan with a fault pulse instead of done.

Top module: `bracket_match_scan`

## Requirements
- R1: A start pulse while the block is idle begins a scan. The depth is set to one and the direction input (0 forward, 1 backward) is captured. Start and direction are ignored while a scan is running or finishing, so they do not change its result or timing.
- R2: In a forward scan the head is stepped forward. An opening bracket byte (8'h5B) adds one to the depth and a closing bracket byte (8'h5D) subtracts one.
- R3: In a backward scan the head is stepped backward and the bracket roles are swapped. 8'h5D adds one to the depth and 8'h5B subtracts one.
- R4: When the depth returns to zero, done is high for exactly one cycle. The head is left on the matching bracket and no further step is issued.
- R5: Every byte other than the two bracket codes is passed over without changing the depth.
- R6: Each cell costs two cycles: one cycle with a step strobe, then one read cycle. A match found d cells away raises done 2·d clock edges after the edge that sampled start.
- R7: Nesting up to 255 levels deep is tracked correctly.
- R8: A deepening bracket read while the depth is already 255 raises fault for one cycle and ends the scan. This happens 2·d edges after start, with no done.
- R9: If the at-end flag is high in a step cycle, no step is issued. Fault is raised for one cycle, 2·d+1 edges after start, and the scan ends.
- R10: After reset the block is idle, with busy, done, fault and both step strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (used only when idle) |
| scanBack | input | 1 | Direction for the scan: 0 forward, 1 backward |
| codeByte | input | 8 | Byte under the code tape head |
| headAtEnd | input | 1 | Head is at the last cell in the scan direction |
| stepFwd | output | 1 | Move the head one cell forward this cycle |
| stepBack | output | 1 | Move the head one cell backward this cycle |
| busy | output | 1 | A scan is stepping or reading |
| done | output | 1 | One-cycle pulse: match found |
| fault | output | 1 | One-cycle pulse: depth overflow or end of tape |

## Verification
The hardest case to reach is the depth overflow. It needs 256 nested brackets on the tape, and the depth must sit at its ceiling in the same read cycle that another deepening bracket appears. The bench therefore models a 520-cell tape that moves on the step strobes. For the overflow case it fills the first 257 cells with opening brackets. For the full-depth case it writes 255 opening brackets followed by 255 closing ones. Start and direction are also disturbed partway through a scan, to show that a running scan keeps its captured direction.

// File: rtl/brscan_pkg.sv
package brscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MOVE,
    ST_READ,
    ST_MATCH,
    ST_FAULT
  } scanState_t;

  // strobes from control to the depth datapath
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } depthCmd_t;

endpackage

// File: rtl/brscan_depth.sv
module brscan_depth
  import brscan_pkg::*;
#(
  parameter int DEPTH_W = 8,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] OPEN_CODE = 8'h5B,
  parameter logic [CODE_W-1:0] CLOSE_CODE = 8'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  depthCmd_t         cmd,
  input  logic              dirIn,
  input  logic [CODE_W-1:0] codeByte,
  output logic              dirLatched,
  output logic              nestByte,
  output logic              unnestByte,
  output logic              depthAtOne,
  output logic              depthAtMax
);

  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

  logic [DEPTH_W-1:0] depth;
  logic               dirQ;
  logic               isOpen;
  logic               isClose;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      dirQ  <= 1'b0;
    end else if (cmd.load) begin
      depth <= DEPTH_ONE;
      dirQ  <= dirIn;
    end else if (cmd.inc) begin
      depth <= depth + DEPTH_ONE;
    end else if (cmd.dec) begin
      depth <= depth - DEPTH_ONE;
    end
  end

  assign isOpen  = (codeByte == OPEN_CODE);
  assign isClose = (codeByte == CLOSE_CODE);

  // direction swaps which bracket deepens the nesting
  always_comb begin
    if (dirQ) begin
      nestByte   = isClose;
      unnestByte = isOpen;
    end else begin
      nestByte   = isOpen;
      unnestByte = isClose;
    end
  end

  assign dirLatched = dirQ;
  assign depthAtOne = (depth == DEPTH_ONE);
  assign depthAtMax = (depth == DEPTH_MAX);

endmodule

// File: rtl/brscan_ctrl.sv
module brscan_ctrl
  import brscan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      headAtEnd,
  input  logic      dirLatched,
  input  logic      nestByte,
  input  logic      unnestByte,
  input  logic      depthAtOne,
  input  logic      depthAtMax,
  output depthCmd_t cmd,
  output logic      stepFwd,
  output logic      stepBack,
  output logic      busy,
  output logic      done,
  output logic      fault
);

  scanState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.load  = 1'b1;
          stateNext = ST_MOVE;
        end
      end
      ST_MOVE: begin
        stateNext = headAtEnd ? ST_FAULT : ST_READ;
      end
      ST_READ: begin
        if (nestByte) begin
          if (depthAtMax) begin
            stateNext = ST_FAULT;
          end else begin
            cmd.inc   = 1'b1;
            stateNext = ST_MOVE;
          end
        end else if (unnestByte) begin
          cmd.dec   = 1'b1;
          stateNext = depthAtOne ? ST_MATCH : ST_MOVE;
        end else begin
          stateNext = ST_MOVE;
        end
      end
      ST_MATCH: stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  logic moving;
  assign moving   = (state == ST_MOVE) && !headAtEnd;
  assign stepFwd  = moving && !dirLatched;
  assign stepBack = moving && dirLatched;
  assign busy     = (state == ST_MOVE) || (state == ST_READ);
  assign done     = (state == ST_MATCH);
  assign fault    = (state == ST_FAULT);

endmodule

// File: rtl/bracket_match_scan.sv
module bracket_match_scan
  import brscan_pkg::*;
#(
  parameter int DEPTH_W = 8,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] OPEN_CODE = 8'h5B,
  parameter logic [CODE_W-1:0] CLOSE_CODE = 8'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              scanBack,
  input  logic [CODE_W-1:0] codeByte,
  input  logic              headAtEnd,
  output logic              stepFwd,
  output logic              stepBack,
  output logic              busy,
  output logic              done,
  output logic              fault
);

  depthCmd_t cmd;
  logic dirLatched, nestByte, unnestByte, depthAtOne, depthAtMax;

  brscan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .headAtEnd  (headAtEnd),
    .dirLatched (dirLatched),
    .nestByte   (nestByte),
    .unnestByte (unnestByte),
    .depthAtOne (depthAtOne),
    .depthAtMax (depthAtMax),
    .cmd        (cmd),
    .stepFwd    (stepFwd),
    .stepBack   (stepBack),
    .busy       (busy),
    .done       (done),
    .fault      (fault)
  );

  brscan_depth #(
    .DEPTH_W    (DEPTH_W),
    .CODE_W     (CODE_W),
    .OPEN_CODE  (OPEN_CODE),
    .CLOSE_CODE (CLOSE_CODE)
  ) u_depth (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .dirIn      (scanBack),
    .codeByte   (codeByte),
    .dirLatched (dirLatched),
    .nestByte   (nestByte),
    .unnestByte (unnestByte),
    .depthAtOne (depthAtOne),
    .depthAtMax (depthAtMax)
  );

endmodule

// File: rtl/bracket_match_scan_chk.sv
module bracket_match_scan_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              scanBack,
  input logic [CODE_W-1:0] codeByte,
  input logic              headAtEnd,
  input logic              stepFwd,
  input logic              stepBack,
  input logic              busy,
  input logic              done,
  input logic              fault
);

  // R1
  start_begins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && !fault) |=> busy);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !fault && !stepFwd && !stepBack));

  // R6
  step_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepFwd || stepBack) |=> (busy && !stepFwd && !stepBack));

  // R6
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stepFwd, stepBack}));

  // R9
  no_step_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepFwd || stepBack) |-> !headAtEnd);

  // R8
  fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!fault && !busy));

endmodule

bind bracket_match_scan bracket_match_scan_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/bracket_match_scan_bench.sv
module bracket_match_scan_bench;

  localparam int TAPE_LEN = 520;
  localparam logic [7:0] OPN = 8'h5B;
  localparam logic [7:0] CLS = 8'h5D;

  typedef struct packed {
    logic [127:0] prog;
    logic [15:0]  startPos;
    logic         back;
    logic [15:0]  endPos;
    logic         expFault;
    logic [15:0]  cycles;
  } vec_t;

  // R2 R3 R5 R6 R9 vectors: 16-char tape prefix, rest filled with '.'
  localparam vec_t VECS [9] = '{
    '{"[ab]............", 16'd0, 1'b0, 16'd3,   1'b0, 16'd6},
    '{"[[]]............", 16'd0, 1'b0, 16'd3,   1'b0, 16'd6},
    '{"[[]]............", 16'd1, 1'b0, 16'd2,   1'b0, 16'd2},
    '{"x[a[b]c]........", 16'd7, 1'b1, 16'd1,   1'b0, 16'd12},
    '{"[][[]]].........", 16'd6, 1'b1, 16'd0,   1'b1, 16'd13},
    '{"[[[..]]]........", 16'd0, 1'b0, 16'd7,   1'b0, 16'd14},
    '{"[...............", 16'd0, 1'b0, 16'd519, 1'b1, 16'd1039},
    '{"..[+-.,<>]......", 16'd2, 1'b0, 16'd9,   1'b0, 16'd14},
    '{"]...............", 16'd0, 1'b1, 16'd0,   1'b1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scanBack = 1'b0;
  logic [7:0] codeByte;
  logic headAtEnd;
  logic stepFwd, stepBack, busy, done, fault;

  logic [7:0] tape [TAPE_LEN];
  int head = 0;
  logic loadReq = 1'b0;
  int loadVal = 0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  bracket_match_scan u_bracket_match_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .scanBack(scanBack),
    .codeByte(codeByte), .headAtEnd(headAtEnd), .stepFwd(stepFwd),
    .stepBack(stepBack), .busy(busy), .done(done), .fault(fault)
  );

  // tape model moved by the step strobes
  always @(posedge clk) begin
    if (loadReq) head <= loadVal;
    else if (stepFwd) head <= head + 1;
    else if (stepBack) head <= head - 1;
  end

  always_comb begin
    codeByte  = tape[head];
    headAtEnd = scanBack ? (head == 0) : (head == TAPE_LEN - 1);
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fillTape(input logic [127:0] prog);
    for (int i = 0; i < TAPE_LEN; i++) tape[i] = 8'h2E;
    for (int i = 0; i < 16; i++) tape[i] = prog[8*(15-i) +: 8];
  endtask

  // pokeAt >= 0 raises start with the opposite direction mid-scan (R1)
  task automatic runScan(input int s, input logic back, input int endPos,
                         input logic expFault, input int cycles,
                         input int pokeAt, input string tag);
    int cnt;
    @(negedge clk);
    loadVal = s;
    loadReq = 1'b1;
    scanBack = back;
    @(negedge clk);
    loadReq = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!(done || fault) && cnt < 3000) begin
      if (cnt == pokeAt) begin
        start = 1'b1;
        scanBack = ~back;
      end
      @(negedge clk);
      if (cnt == pokeAt) begin
        start = 1'b0;
        scanBack = back;
      end
      cnt++;
    end
    chk(done == !expFault, {tag, " done"}, int'(done), int'(!expFault));
    chk(fault == expFault, {tag, " fault"}, int'(fault), int'(expFault));
    chk(head == endPos, {tag, " head"}, head, endPos);
    chk(cnt == cycles, {tag, " cycles"}, cnt, cycles);
    @(negedge clk);
    // R4: pulse lasts one cycle and the head stays put
    chk(!done && !fault && !busy, {tag, " R4 pulse end"}, int'({done, fault, busy}), 0);
    chk(head == endPos, {tag, " R4 head held"}, head, endPos);
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    fillTape(VECS[0].prog);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !fault && !stepFwd && !stepBack, "R10 in reset",
        int'({busy, done, fault, stepFwd, stepBack}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !stepFwd && !stepBack, "R10 after reset",
        int'({busy, done, fault, stepFwd, stepBack}), 0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 9; v++) begin
      fillTape(VECS[v].prog);
      runScan(int'(VECS[v].startPos), VECS[v].back, int'(VECS[v].endPos),
              VECS[v].expFault, int'(VECS[v].cycles), -1, $sformatf("vec%0d R2/R3/R5/R6/R9", v));
    end

    // R1: start and direction ignored mid-scan
    fillTape(VECS[3].prog);
    runScan(7, 1'b1, 1, 1'b0, 12, 3, "R1 mid-scan start");
    fillTape(VECS[0].prog);
    runScan(0, 1'b0, 3, 1'b0, 6, 4, "R1 late start");

    // R7: 255 levels of nesting, then all unwound
    for (int i = 0; i < TAPE_LEN; i++) tape[i] = 8'h2E;
    for (int i = 0; i < 255; i++) tape[i] = OPN;
    for (int i = 255; i < 510; i++) tape[i] = CLS;
    runScan(0, 1'b0, 509, 1'b0, 1018, -1, "R7 max depth");

    // R8: one level past the ceiling
    for (int i = 0; i < TAPE_LEN; i++) tape[i] = 8'h2E;
    for (int i = 0; i < 257; i++) tape[i] = OPN;
    runScan(0, 1'b0, 255, 1'b1, 510, -1, "R8 overflow");

    // R10: reset in the middle of a scan returns to idle
    fillTape(VECS[5].prog);
    @(negedge clk);
    loadVal = 0;
    loadReq = 1'b1;
    scanBack = 1'b0;
    @(negedge clk);
    loadReq = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !stepFwd && !stepBack, "R10 mid-scan reset",
        int'({busy, done, fault, stepFwd, stepBack}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule